// File: doc/BRIEF.md
# Card Interface Power-Mode Controller

This block is the digital control core of a smart card reader front end. Host control inputs reach it through a chip-select gate. These inputs are the session request, card reset, two clock-divider selects and two supply-voltage selects. While the gate is open they flow straight through. While it is closed they are frozen at the last value seen with the gate open, and the host-side data lines are isolated.

From the gated inputs the controller decides the operating mode: Shutdown, Deep Shutdown, Activating, Active or Deactivating. It drives plain enables for the supply generators, the oscillator speed, the voltage supervisor and the host-line drivers. It also drives a card-presence status output with its own output enable. The analog generators and the card activation timing sit outside the block. They report back through two done inputs.

Card presence is debounced before use. The only exception is Deep Shutdown, where the status output follows the raw contact directly. There is no data stream through the block, so it has no valid/ready interface. Every pin is a level signal sampled on the clock, and no back-pressure exists.

Top module: `cardif_mode_ctrl`

## Requirements
- R1: While `host_sel` is 1, each `ctl_*` output equals its matching input in the same cycle, with no clock delay.
- R2: While `host_sel` is 0, the `ctl_*` outputs hold the values sampled at the last clock edge with `host_sel` at 1. The mode logic sees only these held values.
- R3: While `host_sel` is 0, `host_line_z` is 1 and `card_pres_oe` is 0. While `host_sel` is 1, `card_pres_oe` is 1.
- R4: After reset the mode is Shutdown. In Shutdown `gen_en` is 0, `osc_fast` is 0, `supervisor_en` is 1 and `host_line_z` is 1.
- R5: `mode_state` is one-hot: bit 0 is Shutdown, bit 1 Deep Shutdown, bit 2 Activating, bit 3 Active, bit 4 Deactivating. From Shutdown, a gated session request of 1 together with `vsel_hi` = 0 and `lowv_en_n` = 0 enters Deep Shutdown at the next edge.
- R6: The Deep Shutdown pattern is ignored in Activating, Active and Deactivating. It takes effect one edge after Shutdown is reached.
- R7: In Deep Shutdown, `supervisor_en`, `gen_en` and `osc_fast` are 0, and `card_pres` equals `card_present_raw` combinationally.
- R8: A change of any of the three gated pins (session request, `vsel_hi`, `lowv_en_n`) away from the entry pattern leaves Deep Shutdown at the next edge. The next mode is Activating if the session request is 0, otherwise Shutdown.
- R9: The debounced presence takes a new raw level only after `DEB_CYCLES` consecutive edges that see that level. A shorter excursion leaves it unchanged. In Deep Shutdown the count is held at zero and the debounced level is frozen.
- R10: A gated session request of 0 in Shutdown moves to Activating, where `gen_en` and `osc_fast` are 1. `act_done` then moves to Active. In Active with `host_sel` at 1, `host_line_z` is 0.
- R11: A gated session request of 1 in Activating or Active moves to Deactivating, and this wins over `act_done` in the same cycle. `deact_done` then returns the block to Shutdown.
- R12: Outside Deep Shutdown, `card_pres` is the debounced presence level, which resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Chip select; 1 opens the control gate |
| sess_req_n | input | 1 | Session request, active low |
| card_rst_req | input | 1 | Card reset request |
| clkdiv_sel | input | 2 | Card clock divider select |
| vsel_hi | input | 1 | Supply select, 1 for the high voltage |
| lowv_en_n | input | 1 | Low-voltage supply enable, active low |
| card_present_raw | input | 1 | Undebounced card-presence contact |
| act_done | input | 1 | Activation sequence finished |
| deact_done | input | 1 | Deactivation sequence finished |
| ctl_sess_req_n | output | 1 | Gated session request |
| ctl_card_rst | output | 1 | Gated card reset |
| ctl_clkdiv | output | 2 | Gated divider select |
| ctl_vsel_hi | output | 1 | Gated supply select |
| ctl_lowv_en_n | output | 1 | Gated low-voltage enable |
| host_line_z | output | 1 | 1 puts the host data lines in pull-up high-impedance |
| card_pres | output | 1 | Card-presence status |
| card_pres_oe | output | 1 | Output enable of `card_pres` |
| gen_en | output | 1 | Supply generator enable |
| osc_fast | output | 1 | 1 selects the fast oscillator |
| supervisor_en | output | 1 | Voltage supervisor enable |
| mode_state | output | 5 | One-hot mode |

## Verification
Two events can fall in the same cycle. One is the closing of the chip-select gate. The other is a change on a Deep Shutdown exit pin. The bench provokes this by dropping `host_sel` on the edge where `lowv_en_n` rises while the block sits in Deep Shutdown. The mode must stay in Deep Shutdown because the frozen value still matches the entry pattern, and it must leave only once the gate reopens.

A second collision is a session release arriving together with `act_done`. Deactivation must win. A behavioural model in the bench follows every edge, and all outputs are compared against it each cycle.

// File: rtl/cardif_pkg.sv
package cardif_pkg;
  localparam int MODE_W  = 5;
  localparam int IX_SHUT = 0;
  localparam int IX_DEEP = 1;
  localparam int IX_ACTG = 2;
  localparam int IX_ACTV = 3;
  localparam int IX_DEAC = 4;

  localparam logic [MODE_W-1:0] OH_SHUT = MODE_W'(1) << IX_SHUT;
  localparam logic [MODE_W-1:0] OH_DEEP = MODE_W'(1) << IX_DEEP;
  localparam logic [MODE_W-1:0] OH_ACTG = MODE_W'(1) << IX_ACTG;
  localparam logic [MODE_W-1:0] OH_ACTV = MODE_W'(1) << IX_ACTV;
  localparam logic [MODE_W-1:0] OH_DEAC = MODE_W'(1) << IX_DEAC;

  // trio order: {session request, high-voltage select, low-voltage enable}
  localparam logic [2:0] DEEP_PATTERN = 3'b100;

  typedef struct packed {
    logic       sess_n;
    logic       crst;
    logic [1:0] cdiv;
    logic       vhi;
    logic       lv_n;
  } ctl_t;

  localparam ctl_t CTL_RST = '{sess_n: 1'b1, crst: 1'b0, cdiv: 2'b00,
                               vhi: 1'b1, lv_n: 1'b1};
endpackage

// File: rtl/cardif_cs_gate.sv
module cardif_cs_gate
  import cardif_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel,
  input  ctl_t din,
  output ctl_t dout
);
  ctl_t held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held <= CTL_RST;
    else if (sel) held <= din;
  end

  // open gate is transparent, closed gate shows the frozen copy
  assign dout = sel ? din : held;
endmodule

// File: rtl/cardif_debounce.sv
module cardif_debounce #(
  parameter int DEB_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic freeze,
  input  logic raw,
  output logic level
);
  localparam int CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      level <= 1'b0;
    end else if (freeze || (raw == level)) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      level <= raw;
      cnt   <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cardif_mode_fsm.sv
module cardif_mode_fsm
  import cardif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sess_n,
  input  logic              vhi,
  input  logic              lv_n,
  input  logic              act_done,
  input  logic              deact_done,
  output logic [MODE_W-1:0] mode
);
  logic [MODE_W-1:0] mode_nx;
  logic [2:0]        snap;
  logic              snap_ld;
  logic [2:0]        trio;

  assign trio = {sess_n, vhi, lv_n};

  always_comb begin
    mode_nx = mode;
    snap_ld = 1'b0;
    if (mode[IX_SHUT]) begin
      if (!sess_n) begin
        mode_nx = OH_ACTG;
      end else if (trio == DEEP_PATTERN) begin
        mode_nx = OH_DEEP;
        snap_ld = 1'b1;
      end
    end else if (mode[IX_DEEP]) begin
      if (trio != snap) mode_nx = sess_n ? OH_SHUT : OH_ACTG;
    end else if (mode[IX_ACTG]) begin
      if (sess_n)        mode_nx = OH_DEAC;
      else if (act_done) mode_nx = OH_ACTV;
    end else if (mode[IX_ACTV]) begin
      if (sess_n) mode_nx = OH_DEAC;
    end else if (mode[IX_DEAC]) begin
      if (deact_done) mode_nx = OH_SHUT;
    end else begin
      mode_nx = OH_SHUT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= OH_SHUT;
      snap <= '0;
    end else begin
      mode <= mode_nx;
      if (snap_ld) snap <= trio;
    end
  end
endmodule

// File: rtl/cardif_mode_ctrl.sv
module cardif_mode_ctrl
  import cardif_pkg::*;
#(
  parameter int DEB_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_sel,
  input  logic        sess_req_n,
  input  logic        card_rst_req,
  input  logic [1:0]  clkdiv_sel,
  input  logic        vsel_hi,
  input  logic        lowv_en_n,
  input  logic        card_present_raw,
  input  logic        act_done,
  input  logic        deact_done,
  output logic        ctl_sess_req_n,
  output logic        ctl_card_rst,
  output logic [1:0]  ctl_clkdiv,
  output logic        ctl_vsel_hi,
  output logic        ctl_lowv_en_n,
  output logic        host_line_z,
  output logic        card_pres,
  output logic        card_pres_oe,
  output logic        gen_en,
  output logic        osc_fast,
  output logic        supervisor_en,
  output logic [4:0]  mode_state
);
  ctl_t              ctl_raw, ctl_eff;
  logic [MODE_W-1:0] mode;
  logic              pres_db;
  logic              in_deep, powered;

  assign ctl_raw = '{sess_n: sess_req_n, crst: card_rst_req, cdiv: clkdiv_sel,
                     vhi: vsel_hi, lv_n: lowv_en_n};

  cardif_cs_gate u_gate (
    .clk  (clk),
    .rst_n(rst_n),
    .sel  (host_sel),
    .din  (ctl_raw),
    .dout (ctl_eff)
  );

  cardif_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .sess_n    (ctl_eff.sess_n),
    .vhi       (ctl_eff.vhi),
    .lv_n      (ctl_eff.lv_n),
    .act_done  (act_done),
    .deact_done(deact_done),
    .mode      (mode)
  );

  assign in_deep = mode[IX_DEEP];

  cardif_debounce #(.DEB_CYCLES(DEB_CYCLES)) u_deb (
    .clk   (clk),
    .rst_n (rst_n),
    .freeze(in_deep),
    .raw   (card_present_raw),
    .level (pres_db)
  );

  assign powered        = mode[IX_ACTG] | mode[IX_ACTV] | mode[IX_DEAC];
  assign ctl_sess_req_n = ctl_eff.sess_n;
  assign ctl_card_rst   = ctl_eff.crst;
  assign ctl_clkdiv     = ctl_eff.cdiv;
  assign ctl_vsel_hi    = ctl_eff.vhi;
  assign ctl_lowv_en_n  = ctl_eff.lv_n;
  assign host_line_z    = !host_sel || !mode[IX_ACTV];
  assign card_pres_oe   = host_sel;
  assign card_pres      = in_deep ? card_present_raw : pres_db;
  assign gen_en         = powered;
  assign osc_fast       = powered;
  assign supervisor_en  = !in_deep;
  assign mode_state     = mode;
endmodule

// File: rtl/cardif_mode_ctrl_chk.sv
module cardif_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       host_sel,
  input logic       card_present_raw,
  input logic       ctl_sess_req_n,
  input logic [1:0] ctl_clkdiv,
  input logic       ctl_lowv_en_n,
  input logic       host_line_z,
  input logic       card_pres,
  input logic       card_pres_oe,
  input logic       gen_en,
  input logic       supervisor_en,
  input logic [4:0] mode_state
);
  p_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_state) == 1);

  p_cs_isolate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !host_sel |-> (host_line_z && !card_pres_oe));

  p_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_sel && $past(!host_sel)) |->
      ($stable(ctl_clkdiv) && $stable(ctl_sess_req_n) && $stable(ctl_lowv_en_n)));

  p_deep_from_shut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_state[1]) |-> $past(mode_state[0]));

  p_deep_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mode_state[1] |-> (!supervisor_en && !gen_en && (card_pres == card_present_raw)));

  p_deep_exit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_state[1]) |-> (mode_state[0] || mode_state[2]));

  p_active_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_state[3]) |-> $past(mode_state[2]));

  p_deact_entry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_state[4]) |-> $past(mode_state[2] || mode_state[3]));
endmodule

bind cardif_mode_ctrl cardif_mode_ctrl_chk i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .host_sel        (host_sel),
  .card_present_raw(card_present_raw),
  .ctl_sess_req_n  (ctl_sess_req_n),
  .ctl_clkdiv      (ctl_clkdiv),
  .ctl_lowv_en_n   (ctl_lowv_en_n),
  .host_line_z     (host_line_z),
  .card_pres       (card_pres),
  .card_pres_oe    (card_pres_oe),
  .gen_en          (gen_en),
  .supervisor_en   (supervisor_en),
  .mode_state      (mode_state)
);

// File: tb/test_cardif_mode_ctrl.sv
`timescale 1ns/1ps
module test_cardif_mode_ctrl;
  localparam int DEB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_sel = 1'b1, sess_req_n = 1'b1, card_rst_req = 1'b0;
  logic [1:0] clkdiv_sel = 2'b00;
  logic vsel_hi = 1'b1, lowv_en_n = 1'b1, card_present_raw = 1'b0;
  logic act_done = 1'b0, deact_done = 1'b0;
  logic ctl_sess_req_n, ctl_card_rst, ctl_vsel_hi, ctl_lowv_en_n;
  logic [1:0] ctl_clkdiv;
  logic host_line_z, card_pres, card_pres_oe, gen_en, osc_fast, supervisor_en;
  logic [4:0] mode_state;

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference state: 0 shut, 1 deep, 2 activating, 3 active, 4 deactivating
  int   m_mode = 0;
  int   m_cnt  = 0;
  logic m_db   = 1'b0;
  logic h_sess = 1'b1, h_rst = 1'b0, h_vh = 1'b1, h_lv = 1'b1;
  logic [1:0] h_div = 2'b00;

  always #4 clk = ~clk;

  cardif_mode_ctrl #(.DEB_CYCLES(DEB)) i_cardif_mode_ctrl (.*);

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: got %0h expected %0h", req, $time, got, exp);
    end
  endtask

  function automatic logic e_sess(); return host_sel ? sess_req_n : h_sess; endfunction
  function automatic logic e_vh();   return host_sel ? vsel_hi    : h_vh;   endfunction
  function automatic logic e_lv();   return host_sel ? lowv_en_n  : h_lv;   endfunction

  task automatic model_edge();
    int nm;
    if (!rst_n) begin
      m_mode = 0; m_cnt = 0; m_db = 1'b0;
      h_sess = 1'b1; h_rst = 1'b0; h_div = 2'b00; h_vh = 1'b1; h_lv = 1'b1;
      return;
    end
    nm = m_mode;
    case (m_mode)
      0: if (!e_sess()) nm = 2; else if (!e_vh() && !e_lv()) nm = 1;
      1: if (!(e_sess() && !e_vh() && !e_lv())) nm = e_sess() ? 0 : 2;
      2: if (e_sess()) nm = 4; else if (act_done) nm = 3;
      3: if (e_sess()) nm = 4;
      default: if (deact_done) nm = 0;
    endcase
    if (m_mode == 1 || card_present_raw == m_db) m_cnt = 0;
    else if (m_cnt == DEB - 1) begin m_db = card_present_raw; m_cnt = 0; end
    else m_cnt++;
    if (host_sel) begin
      h_sess = sess_req_n; h_rst = card_rst_req; h_div = clkdiv_sel;
      h_vh = vsel_hi; h_lv = lowv_en_n;
    end
    m_mode = nm;
  endtask

  task automatic compare();
    logic pw;
    pw = (m_mode >= 2);
    chk("R5 mode", {3'b0, mode_state}, 8'(1 << m_mode));
    chk("R10 gen_en", {7'b0, gen_en}, {7'b0, pw});
    chk("R10 osc_fast", {7'b0, osc_fast}, {7'b0, pw});
    chk("R7 supervisor_en", {7'b0, supervisor_en}, {7'b0, m_mode != 1});
    chk("R3 host_line_z", {7'b0, host_line_z}, {7'b0, !host_sel || m_mode != 3});
    chk("R3 card_pres_oe", {7'b0, card_pres_oe}, {7'b0, host_sel});
    chk("R12 card_pres", {7'b0, card_pres}, {7'b0, (m_mode == 1) ? card_present_raw : m_db});
    chk("R1 ctl", {2'b0, ctl_sess_req_n, ctl_card_rst, ctl_clkdiv, ctl_vsel_hi, ctl_lowv_en_n},
        host_sel ? {2'b0, sess_req_n, card_rst_req, clkdiv_sel, vsel_hi, lowv_en_n}
                 : {2'b0, h_sess, h_rst, h_div, h_vh, h_lv});
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_edge();
      #2;
      compare();
    end
  endtask

  task automatic run_all();
    cyc(3);
    rst_n = 1'b1;
    cyc();
    chk("R4 mode", {3'b0, mode_state}, 8'h01);
    chk("R4 gen", {7'b0, gen_en}, 8'h00);
    chk("R4 osc", {7'b0, osc_fast}, 8'h00);
    chk("R4 sup", {7'b0, supervisor_en}, 8'h01);
    chk("R4 lines", {7'b0, host_line_z}, 8'h01);
    // R1 transparency
    clkdiv_sel = 2'b10; card_rst_req = 1'b1; #1;
    chk("R1 div", {6'b0, ctl_clkdiv}, 8'h02);
    cyc();
    // R2 / R3 frozen and isolated
    host_sel = 1'b0; sess_req_n = 1'b0; clkdiv_sel = 2'b01; #1;
    chk("R2 div held", {6'b0, ctl_clkdiv}, 8'h02);
    chk("R3 z", {7'b0, host_line_z}, 8'h01);
    chk("R3 oe", {7'b0, card_pres_oe}, 8'h00);
    cyc(2);
    chk("R2 no activation", {3'b0, mode_state}, 8'h01);
    // R10 activation
    host_sel = 1'b1; cyc();
    chk("R10 activating", {3'b0, mode_state}, 8'h04);
    chk("R10 gen", {7'b0, gen_en}, 8'h01);
    act_done = 1'b1; cyc(); act_done = 1'b0;
    chk("R10 active", {3'b0, mode_state}, 8'h08);
    chk("R10 lines driven", {7'b0, host_line_z}, 8'h00);
    // R6 deep request ignored while a session runs
    vsel_hi = 1'b0; lowv_en_n = 1'b0; cyc(2);
    chk("R6 stays active", {3'b0, mode_state}, 8'h08);
    sess_req_n = 1'b1; cyc();
    chk("R11 deactivating", {3'b0, mode_state}, 8'h10);
    cyc(2);
    deact_done = 1'b1; cyc(); deact_done = 1'b0;
    chk("R6 shutdown first", {3'b0, mode_state}, 8'h01);
    cyc();
    chk("R5 deep", {3'b0, mode_state}, 8'h02);
    // R7 presence follows raw contact
    card_present_raw = 1'b1; #1;
    chk("R7 pres follows", {7'b0, card_pres}, 8'h01);
    chk("R7 sup off", {7'b0, supervisor_en}, 8'h00);
    card_present_raw = 1'b0; #1;
    chk("R7 pres follows low", {7'b0, card_pres}, 8'h00);
    cyc();
    // R8 exits
    lowv_en_n = 1'b1; cyc();
    chk("R8 exit to shut", {3'b0, mode_state}, 8'h01);
    lowv_en_n = 1'b0; cyc();
    sess_req_n = 1'b0; cyc();
    chk("R8 exit to activation", {3'b0, mode_state}, 8'h04);
    // R11 release beats act_done
    act_done = 1'b1; sess_req_n = 1'b1; cyc(); act_done = 1'b0;
    chk("R11 abort wins", {3'b0, mode_state}, 8'h10);
    deact_done = 1'b1; cyc(); deact_done = 1'b0;
    cyc();
    chk("R6 deep after shut", {3'b0, mode_state}, 8'h02);
    // gate closes on the same edge an exit pin changes
    host_sel = 1'b0; lowv_en_n = 1'b1; cyc(2);
    chk("R2 masked exit", {3'b0, mode_state}, 8'h02);
    host_sel = 1'b1; cyc();
    chk("R8 exit after reopen", {3'b0, mode_state}, 8'h01);
    // R9 debounce
    card_present_raw = 1'b1; cyc(DEB - 1);
    card_present_raw = 1'b0; cyc();
    chk("R9 glitch ignored", {7'b0, card_pres}, 8'h00);
    card_present_raw = 1'b1; cyc(DEB);
    chk("R9 settled", {7'b0, card_pres}, 8'h01);
    lowv_en_n = 1'b0; cyc();
    card_present_raw = 1'b0; cyc(DEB + 2);
    vsel_hi = 1'b1; cyc();
    chk("R9 frozen in deep", {7'b0, card_pres}, 8'h01);
    cyc(DEB);
    chk("R9 settles after deep", {7'b0, card_pres}, 8'h00);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(200000 * 8);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule